// File: doc/BRIEF.md
# Field-Drive Load-Response Rate Limiter

This block sits between an analog regulation comparator and the gate driver of an alternator field switch. The comparator produces a raw on/off bit whose duty tracks the system voltage error; on its own that duty can jump from a low value to full-on in one period when a heavy electrical load is switched in. At low engine speed such a jump loads the engine suddenly, so this block lets the field duty rise only at a controlled rate. Falling duty is still passed through quickly.

A free-running prescaler divides the oscillator into fixed PWM periods of 256 clocks. Its upper nibble builds a ladder of digital duty levels, and a 4-bit index picks one rung. Once per period the block counts how many clocks the raw bit was high and compares that count with the selected rung. The index then moves up or down through a divider whose ratio depends on two rate-select pins, a speed flag, a startup hold and a test pin. The gate enable is the raw bit ANDed with the digital rung, ORed with a short floor pulse at the start of every period, and qualified by two external enables.

Top module: `lrc_rate_limiter`

## Requirements
- R1: The prescaler counts 0 to 255 and wraps, so one PWM period is 256 clocks. The floor pulse is high for clocks 0 to 7 of each period, so with the raw bit low and both enables high the gate is high for exactly 8 clocks per period.
- R2: While `rst_n` is low the gate enable is low whatever the other inputs do.
- R3: Index k (0 to 11) gives a digital rung that is high while the prescaler's upper nibble is below 5+k, which is (5+k)/16 of the period. Index 11 gives 100%. With the raw bit held high and both enables high, the gate is high for (5+k)*16 clocks per period.
- R4: When stepping up, with the speed flag low, the index moves once every N divider ticks. N is 264 for {rsel2_i,rsel1_i}=00, 198 for 01, 132 for 10 and 66 for 11 (a pin driven high stands for an open pin).
- R5: With `test_i` low a divider tick occurs at the last clock of every period. With `test_i` high it occurs every 16 clocks (low nibble of the prescaler equal to 15), so every rate runs 16 times faster.
- R6: When stepping down, or when stepping up with the speed flag high and no startup hold, the index moves once every 4 ticks.
- R7: Reset and a high `start_i` set a startup hold; a high `vreg_ok_i` clears it (`start_i` wins if both are high). While the hold is set, stepping up uses the pin-selected rate even with the speed flag high.
- R8: At the last clock of each period the count of high raw samples in that period is compared with (5+k)*16. The direction for the next period is up if the count is larger, down if smaller and hold (no stepping) if equal.
- R9: The index stops at 11 going up and at 0 going down; it never wraps.
- R10: While `below_min_i` is high the direction is down from that cycle on, whatever the measurement says, so the index falls to 0 and the rung settles at 31.25%.
- R11: The gate enable is ((raw AND rung) OR floor pulse) AND `no_dump_i` AND `poll_ok_i`.
- R12: Reset clears the prescaler, divider and index to 0 and the direction to hold, so the first period after reset runs at index 0 with no stepping.
- R13: The divider restarts from 0 whenever the effective direction changes or is hold. When its limit shrinks below the count already reached, the index steps at the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_raw_i | input | 1 | Raw on/off bit from the analog regulation comparator |
| rsel1_i | input | 1 | Rate-select pin, low bit of the rate code (high = open) |
| rsel2_i | input | 1 | Rate-select pin, high bit of the rate code (high = open) |
| test_i | input | 1 | Accelerated test: divider ticks every 16 clocks |
| hi_speed_i | input | 1 | Rotor frequency above the high-speed threshold |
| below_min_i | input | 1 | Rotor frequency below the minimum detection threshold |
| start_i | input | 1 | Ignition-on startup indication, sets the startup hold |
| vreg_ok_i | input | 1 | System voltage has reached the set point, clears the hold |
| no_dump_i | input | 1 | High when no load-dump condition exists |
| poll_ok_i | input | 1 | Gate-polling enable |
| gate_en_o | output | 1 | Final field gate enable |

## Verification
The sweeps drive the raw bit as full-on, off, or high in only the last 80 clocks of a period, and predict the gate level for every clock from a closed-form index trajectory. Each rate code is run under test acceleration long enough to see several steps, and the fastest one until the index stops at 11; a wrong rate table or a tick taken from the wrong counter bit shifts every later step by whole periods. The descent from 11 to 0 checks the fast down rate and the stop at hold once the count equals the rung; a design that wrapped below 0 would show a 100% rung where 31.25% is expected. A startup hold that is re-armed by `start_i`, and then released after the divider has passed the smaller limit, exposes both a hold that does not work and a divider that compares with equality instead of with a limit.

// File: rtl/lrc_pkg.sv
// Package: shared types and helpers for the load-response rate limiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lrc_pkg;

    // Direction of index stepping decided once per PWM period.
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_t;

    // Largest of four divider limits, used to size the divider counter.
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lrc_prescaler.sv
// Module: free-running prescaler that defines the PWM period.
// Counts 0..2^CNT_W-1 and wraps; flags the last clock of a period and the
// last clock of every 2^TEST_W-clock sub-period. Assumes TEST_W < CNT_W.
module lrc_prescaler #(
    parameter int CNT_W  = 8,
    parameter int TEST_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             period_end_o,
    output logic             sub_end_o
);

    logic [CNT_W-1:0] cnt_q;

    // Advance the period counter every clock, clearing it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Decode period and sub-period boundaries from the current count.
    always_comb begin
        period_end_o = &cnt_q;
        sub_end_o    = &cnt_q[TEST_W-1:0];
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/lrc_ladder.sv
// Module: digital duty ladder.
// Turns the index into a rung level BASE_LVL+idx (in 1/2^LVL_W units of a
// period), drives the digital PWM from the prescaler's top LVL_W bits, and
// gives the same level in clock counts for the duty comparison.
// Assumes BASE_LVL + IDX_MAX <= 2^LVL_W so the top rung is exactly 100%.
module lrc_ladder #(
    parameter int CNT_W    = 8,
    parameter int LVL_W    = 4,
    parameter int IDX_W    = 4,
    parameter int BASE_LVL = 5
) (
    input  logic [LVL_W-1:0] cnt_hi_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             dig_on_o,
    output logic [CNT_W:0]   thr_o
);

    localparam int LW = CNT_W + 1;
    localparam int SH = CNT_W - LVL_W;

    logic [CNT_W:0] level;

    // Compute the rung level, the digital PWM bit and the clock-count threshold.
    always_comb begin
        level    = LW'(BASE_LVL) + LW'(idx_i);
        dig_on_o = (LW'(cnt_hi_i) < level);
        thr_o    = level << SH;
    end

endmodule

// File: rtl/lrc_duty_meter.sv
// Module: per-period duty measurement of the raw regulation bit.
// Counts high samples across one period and, at the period's last clock,
// compares the total with the rung threshold to choose the next direction.
// Assumes period_end_i pulses for exactly one clock per period.
module lrc_duty_meter #(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwm_i,
    input  logic                period_end_i,
    input  logic [CNT_W:0]      thr_i,
    output lrc_pkg::step_dir_t  dir_o
);

    import lrc_pkg::*;

    localparam int LW = CNT_W + 1;

    logic [CNT_W:0] acc_q;
    logic [CNT_W:0] total;
    step_dir_t      dir_q;
    step_dir_t      dir_next;

    // Form this period's total and the direction it implies.
    always_comb begin
        total = acc_q + LW'(pwm_i);
        if (total > thr_i)      dir_next = DIR_UP;
        else if (total < thr_i) dir_next = DIR_DOWN;
        else                    dir_next = DIR_HOLD;
    end

    // Accumulate samples and latch the direction at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            dir_q <= DIR_HOLD;
        end else if (period_end_i) begin
            acc_q <= '0;
            dir_q <= dir_next;
        end else begin
            acc_q <= total;
        end
    end

    assign dir_o = dir_q;

endmodule

// File: rtl/lrc_rate_div.sv
// Module: step-rate divider.
// Counts divider ticks while a direction is active and emits a one-clock
// step when the count reaches the active limit. Slow stepping uses the
// pin-selected limit, otherwise FAST_TICKS. Restarts on direction change.
// Assumes all limits are at least 1.
module lrc_rate_div #(
    parameter int RATE_00    = 264,
    parameter int RATE_01    = 198,
    parameter int RATE_10    = 132,
    parameter int RATE_11    = 66,
    parameter int FAST_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  lrc_pkg::step_dir_t dir_i,
    input  logic               slow_i,
    input  logic [1:0]         rsel_i,
    output logic               step_o
);

    import lrc_pkg::*;

    localparam int MAXR  = max_of4(max_of4(RATE_00, RATE_01, RATE_10, RATE_11),
                                   FAST_TICKS, 1, 1);
    localparam int DIV_W = $clog2(MAXR + 1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;
    logic [DIV_W:0]   div_inc;
    logic             reached;
    logic             dir_changed;
    step_dir_t        prev_q;

    // Pick the active limit from the pin code or the fast ratio.
    always_comb begin
        if (slow_i) begin
            case (rsel_i)
                2'b00:   limit = DIV_W'(RATE_00);
                2'b01:   limit = DIV_W'(RATE_01);
                2'b10:   limit = DIV_W'(RATE_10);
                default: limit = DIV_W'(RATE_11);
            endcase
        end else begin
            limit = DIV_W'(FAST_TICKS);
        end
    end

    // Decide whether this tick completes a step.
    always_comb begin
        div_inc     = {1'b0, div_q} + 1'b1;
        reached     = (div_inc >= {1'b0, limit});
        dir_changed = (dir_i != prev_q);
        step_o      = tick_i && (dir_i != DIR_HOLD) && !dir_changed && reached;
    end

    // Count ticks, restarting on hold, on a direction change and after a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            prev_q <= DIR_HOLD;
        end else begin
            prev_q <= dir_i;
            if (dir_i == DIR_HOLD || dir_changed) div_q <= '0;
            else if (tick_i)                      div_q <= reached ? '0 : div_inc[DIV_W-1:0];
        end
    end

endmodule

// File: rtl/lrc_step_index.sv
// Module: saturating up/down ladder index.
// Moves one rung per step strobe in the given direction, holding at 0 and
// at IDX_MAX. Assumes IDX_MAX fits in IDX_W bits.
module lrc_step_index #(
    parameter int IDX_W   = 4,
    parameter int IDX_MAX = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  lrc_pkg::step_dir_t dir_i,
    output logic [IDX_W-1:0]   idx_o
);

    import lrc_pkg::*;

    logic [IDX_W-1:0] idx_q;

    // Apply a step within the 0..IDX_MAX range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (step_i) begin
            if (dir_i == DIR_UP && idx_q < IDX_W'(IDX_MAX))  idx_q <= idx_q + 1'b1;
            else if (dir_i == DIR_DOWN && idx_q != '0)       idx_q <= idx_q - 1'b1;
        end
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/lrc_rate_limiter.sv
// Module: load-response duty-cycle rate limiter (top).
// Limits how fast the field-drive duty can rise: the raw regulation bit is
// ANDed with a stepped digital rung whose index climbs at a selectable rate
// and falls at a fast rate, a floor pulse is ORed in, and two enables
// qualify the result. Assumes all inputs are synchronous to clk.
module lrc_rate_limiter #(
    parameter int CNT_W      = 8,
    parameter int LVL_W      = 4,
    parameter int IDX_W      = 4,
    parameter int BASE_LVL   = 5,
    parameter int IDX_MAX    = 11,
    parameter int MIN_ON     = 8,
    parameter int TEST_W     = 4,
    parameter int RATE_00    = 264,
    parameter int RATE_01    = 198,
    parameter int RATE_10    = 132,
    parameter int RATE_11    = 66,
    parameter int FAST_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_raw_i,
    input  logic rsel1_i,
    input  logic rsel2_i,
    input  logic test_i,
    input  logic hi_speed_i,
    input  logic below_min_i,
    input  logic start_i,
    input  logic vreg_ok_i,
    input  logic no_dump_i,
    input  logic poll_ok_i,
    output logic gate_en_o
);

    import lrc_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic             period_end;
    logic             sub_end;
    logic             tick_w;
    logic [IDX_W-1:0] idx_q;
    logic             dig_on;
    logic [CNT_W:0]   thr;
    step_dir_t        meas_dir;
    step_dir_t        eff_dir;
    logic             slow_w;
    logic             step_w;
    logic             boot_hold_q;
    logic             min_on;

    lrc_prescaler #(
        .CNT_W  (CNT_W),
        .TEST_W (TEST_W)
    ) u_presc (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_o        (cnt_q),
        .period_end_o (period_end),
        .sub_end_o    (sub_end)
    );

    lrc_ladder #(
        .CNT_W    (CNT_W),
        .LVL_W    (LVL_W),
        .IDX_W    (IDX_W),
        .BASE_LVL (BASE_LVL)
    ) u_ladder (
        .cnt_hi_i (cnt_q[CNT_W-1 -: LVL_W]),
        .idx_i    (idx_q),
        .dig_on_o (dig_on),
        .thr_o    (thr)
    );

    lrc_duty_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_i        (pwm_raw_i),
        .period_end_i (period_end),
        .thr_i        (thr),
        .dir_o        (meas_dir)
    );

    // Hold the startup rate limit from reset or ignition-on until regulation.
    always_ff @(posedge clk) begin
        if (!rst_n)         boot_hold_q <= 1'b1;
        else if (start_i)   boot_hold_q <= 1'b1;
        else if (vreg_ok_i) boot_hold_q <= 1'b0;
    end

    // Choose tick source, effective direction and slow/fast stepping.
    always_comb begin
        tick_w  = test_i ? sub_end : period_end;
        eff_dir = below_min_i ? DIR_DOWN : meas_dir;
        slow_w  = (eff_dir == DIR_UP) && (!hi_speed_i || boot_hold_q);
    end

    lrc_rate_div #(
        .RATE_00    (RATE_00),
        .RATE_01    (RATE_01),
        .RATE_10    (RATE_10),
        .RATE_11    (RATE_11),
        .FAST_TICKS (FAST_TICKS)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_w),
        .dir_i  (eff_dir),
        .slow_i (slow_w),
        .rsel_i ({rsel2_i, rsel1_i}),
        .step_o (step_w)
    );

    lrc_step_index #(
        .IDX_W   (IDX_W),
        .IDX_MAX (IDX_MAX)
    ) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_w),
        .dir_i  (eff_dir),
        .idx_o  (idx_q)
    );

    // Combine the live bit, the rung, the floor pulse and the enables.
    always_comb begin
        min_on    = (cnt_q < CNT_W'(MIN_ON));
        gate_en_o = rst_n && no_dump_i && poll_ok_i && ((pwm_raw_i && dig_on) || min_on);
    end

endmodule

// File: rtl/lrc_rate_limiter_chk.sv
// Module: assertion checker for the rate limiter, bound to the top.
// Observes ports and the prescaler/index/tick signals driven by the
// sub-blocks. Assumes reset is asserted at time zero.
module lrc_rate_limiter_chk #(
    parameter int CNT_W   = 8,
    parameter int IDX_W   = 4,
    parameter int IDX_MAX = 11,
    parameter int MIN_ON  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [IDX_W-1:0] idx,
    input logic             tick,
    input logic             below_min,
    input logic             pwm,
    input logic             no_dump,
    input logic             poll_ok,
    input logic             gate
);

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt) |=> (cnt == '0)); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cnt) |=> (cnt == $past(cnt) + 1'b1)); // R1

    AST_FLOOR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < CNT_W'(MIN_ON) && no_dump && poll_ok) |-> gate); // R1

    AST_GATE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (pwm || cnt < CNT_W'(MIN_ON))); // R11

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(IDX_MAX)); // R9

    AST_IDX_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (idx == $past(idx) || idx == $past(idx) + 1'b1 || idx == $past(idx) - 1'b1)); // R4

    AST_IDX_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(idx)); // R5

    AST_FORCED_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        below_min |=> (idx <= $past(idx))); // R10

endmodule

bind lrc_rate_limiter lrc_rate_limiter_chk #(
    .CNT_W   (CNT_W),
    .IDX_W   (IDX_W),
    .IDX_MAX (IDX_MAX),
    .MIN_ON  (MIN_ON)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_q),
    .idx       (idx_q),
    .tick      (tick_w),
    .below_min (below_min_i),
    .pwm       (pwm_raw_i),
    .no_dump   (no_dump_i),
    .poll_ok   (poll_ok_i),
    .gate      (gate_en_o)
);

// File: tb/tb_lrc_rate_limiter.sv
`timescale 1ns/1ps
// Bench: sweeps rate codes, modes and duty patterns; predicts the gate level
// for every clock from closed-form index trajectories.
module tb_lrc_rate_limiter;

    localparam int PER = 256;

    logic clk = 1'b0;
    logic rst_n, pwm_raw, rsel1, rsel2, test_m, hi_speed, below_min;
    logic start_p, vreg_ok, no_dump, poll_ok;
    logic gate_en;

    int checks = 0;
    int errors = 0;

    // Scenario state used by the reference model.
    localparam int M_IDLE = 0, M_CLIMB = 1, M_FALL = 2, M_FORCE = 3, M_LATE = 4;
    int sc_mode, sc_n, sc_t, sc_p0;

    always #2 clk = ~clk;

    lrc_rate_limiter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_raw_i   (pwm_raw),
        .rsel1_i     (rsel1),
        .rsel2_i     (rsel2),
        .test_i      (test_m),
        .hi_speed_i  (hi_speed),
        .below_min_i (below_min),
        .start_i     (start_p),
        .vreg_ok_i   (vreg_ok),
        .no_dump_i   (no_dump),
        .poll_ok_i   (poll_ok),
        .gate_en_o   (gate_en)
    );

    // Index while climbing from reset with the raw bit always high.
    function automatic int climb_idx(int tt, int n, int tper);
        int v;
        if (tt < PER) return 0;
        v = (tt - PER) / (n * tper);
        return (v > 11) ? 11 : v;
    endfunction

    function automatic int idx_model(int tt);
        int p, v;
        p = tt / PER;
        case (sc_mode)
            M_CLIMB: v = climb_idx(tt, sc_n, sc_t);
            M_FALL:  v = (p <= sc_p0) ? climb_idx(tt, 4, PER) : 11 - (p - sc_p0 - 1) / 4;
            M_FORCE: v = (p < sc_p0) ? climb_idx(tt, 4, PER)
                                     : climb_idx(sc_p0 * PER, 4, PER) - (p - sc_p0) / 4;
            M_LATE:  v = (p <= 40) ? 0 : 1 + (p - 41) / 4;
            default: v = 0;
        endcase
        if (v < 0) v = 0;
        if (v > 11) v = 11;
        return v;
    endfunction

    function automatic logic pwm_model(int tt);
        if (sc_mode == M_IDLE) return 1'b0;
        if (sc_mode == M_FALL && tt / PER >= sc_p0) return ((tt % PER) >= 176);
        return 1'b1;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; pwm_raw = 1'b1; no_dump = 1'b1; poll_ok = 1'b1;
        below_min = 1'b0; start_p = 1'b0; vreg_ok = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        checks++; // R2: gate low during reset even with every input asking for it
        if (gate_en !== 1'b0) begin
            errors++;
            $display("FAIL R2 gate during reset: got %b expected 0", gate_en);
        end
    endtask

    // Run nper periods, checking each period's gate-high count and every clock.
    task automatic run_scn(string tag, int nper);
        int got, exp_cnt, bad;
        got = 0; exp_cnt = 0; bad = 0;
        for (int t = 0; t < nper * PER; t++) begin
            int c, p, k;
            logic en, e;
            @(negedge clk);
            c = t % PER;
            p = t / PER;
            rst_n     = 1'b1;
            pwm_raw   = pwm_model(t);
            poll_ok   = !(sc_mode == M_FALL && p == 30);
            no_dump   = !(sc_mode == M_FALL && p == 31);
            below_min = (sc_mode == M_FORCE && p >= sc_p0);
            vreg_ok   = ((sc_mode == M_FALL || sc_mode == M_FORCE) && t == 2) ||
                        (sc_mode == M_LATE && (t == 1 || t == 40 * PER));
            start_p   = (sc_mode == M_LATE && t == 3);
            #1;
            k  = idx_model(t);
            en = poll_ok && no_dump;
            e  = en && ((c < 8) || (pwm_raw && (c / 16) < 5 + k));
            if (gate_en) got++;
            if (e) exp_cnt++;
            if (gate_en !== e) bad++;
            if (c == PER - 1) begin
                checks++;
                if (got != exp_cnt || bad != 0) begin
                    errors++;
                    $display("FAIL %s period %0d: gate-high count %0d expected %0d (%0d clocks differ)",
                             tag, p, got, exp_cnt, bad);
                end
                got = 0; exp_cnt = 0; bad = 0;
            end
        end
    endtask

    initial begin
        rsel1 = 1'b0; rsel2 = 1'b0; test_m = 1'b0; hi_speed = 1'b0;

        // R1 R12: raw bit low, only the floor pulse remains, index starts at 0.
        sc_mode = M_IDLE;
        do_reset();
        run_scn("R1/R12 floor pulse", 2);

        // R4 R5 R3 R8: each rate code under test acceleration, raw bit full-on.
        for (int code = 0; code < 4; code++) begin
            sc_mode = M_CLIMB; sc_t = 16;
            case (code)
                0: sc_n = 264;
                1: sc_n = 198;
                2: sc_n = 132;
                default: sc_n = 66;
            endcase
            rsel1 = code[0]; rsel2 = code[1]; test_m = 1'b1; hi_speed = 1'b0;
            do_reset();
            run_scn("R4/R5/R3/R8/R9 climb", 50);
        end

        // R6 R7 R9 R11 R13: fast climb to 11, enables dropped, then fast descent to 0 and hold.
        sc_mode = M_FALL; sc_p0 = 50;
        rsel1 = 1'b0; rsel2 = 1'b0; test_m = 1'b0; hi_speed = 1'b1;
        do_reset();
        run_scn("R6/R7/R8/R9/R11 fall", 100);

        // R7 R13: start re-arms the hold; release after 39 ticks steps at the next tick.
        sc_mode = M_LATE;
        rsel1 = 1'b1; rsel2 = 1'b1; test_m = 1'b0; hi_speed = 1'b1;
        do_reset();
        run_scn("R7/R13 startup hold", 60);

        // R10 R9: below-minimum speed forces the index down to 0 and holds it there.
        sc_mode = M_FORCE; sc_p0 = 22;
        rsel1 = 1'b0; rsel2 = 1'b0; test_m = 1'b0; hi_speed = 1'b1;
        do_reset();
        run_scn("R10/R9 forced down", 56);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(180000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule